// File: doc/BRIEF.md
# Deep Power-Down Entry and Exit Sequencer for SDRAM

This block sits on the controller side of a low-power SDRAM. When host logic asks for sleep, it takes the memory into deep power-down. If a bank is still open, it first issues a precharge-all and waits out the precharge time. It then issues the power-down entry command on the cycle where clock enable falls. While asleep it holds clock enable low and drives only no-operation commands.

A wake request brings clock enable high again. Deep power-down does not keep the array contents, so the block then replays the complete power-up initialization:
- a stabilization wait
- a precharge-all
- two auto-refresh commands, each followed by the row cycle time
- a mode register load, followed by its settling time

Only after all of this does it report ready again. A wake request that arrives while the entry sequence is still running is remembered and acted on once the memory is asleep. All waits are parameters in clock cycles. The stabilization default assumes a 10 ns clock.

Top module: `dpd_seq`

## Requirements
- R1: After reset, ready is 1, busy is 0, clock enable is 1 and the command pins show a no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1) with the address all zero.
- R2: A sleep request while ready, with no bank open, produces the entry command (cs_n=0, ras_n=1, cas_n=1, we_n=0) on the next cycle together with clock enable 0. Clock enable is 1 in the cycle before it.
- R3: A sleep request while ready, with any bank open, first produces a precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, address bit 10 set). Then come TRP_CYC cycles of no-operation, and then the entry command of R2.
- R4: While powered down, clock enable stays 0, the pins show no-operation, and further sleep requests change nothing.
- R5: A wake request while powered down raises clock enable on the next cycle. The pins then show no-operation for STAB_CYC cycles.
- R6: After the stabilization wait, the pins show, in order, each command and then its wait of no-operation cycles:

  | Command | Encoding (cs_n ras_n cas_n we_n) | Wait after it |
  |---|---|---|
  | precharge-all | as in R3 | TRP_CYC |
  | auto-refresh | 0 0 0 1 | TRC_CYC |
  | auto-refresh | 0 0 0 1 | TRC_CYC |
  | mode register load, address = MODE_WORD | 0 0 0 0 | TMRD_CYC |

  Ready returns after the last wait.
- R7: A wake request given during the precharge, precharge wait or entry-command cycles is held. The memory still enters power-down, spends exactly one cycle there, and then starts the exit of R5.
- R8: Busy is the inverse of ready. It rises the cycle after an accepted sleep request and stays high until ready returns.
- R9: A wake request while ready has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter deep power-down |
| wake_req | input | 1 | Request to leave deep power-down |
| bank_open | input | NBANK | One bit per bank, set while that bank has an open row |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins (bit 10 marks precharge-all; mode word on load) |
| ready | output | 1 | Memory initialized and usable |
| busy | output | 1 | Power-down entry, sleep or re-initialization in progress |

## Verification
The bench builds the block with the following parameters:
- STAB_CYC=6, TRP_CYC=3, TRC_CYC=4 and TMRD_CYC=2
- four banks and a 13-bit address
- a distinctive mode word

The short stabilization wait puts the complete exit sequence, and several sleep and wake cycles, inside a brief run. Because every wait has a different length, a miscount in one of them shows up as a command in the wrong cycle. The bench places wake requests on each cycle of the entry sequence, and sleep requests while asleep and during re-initialization. This exercises the held-wake path and the ignored-request paths.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_PALL,
        CMD_REF,
        CMD_MRS,
        CMD_DPD
    } cmd_e;

    typedef enum logic [3:0] {
        ST_RDY,
        ST_PRE,
        ST_PRE_WAIT,
        ST_ENTER,
        ST_SLEEP,
        ST_STAB,
        ST_PALL,
        ST_PALL_WAIT,
        ST_REF,
        ST_REF_WAIT,
        ST_MRS,
        ST_MRS_WAIT
    } state_e;

endpackage

// File: rtl/dpd_timer.sv
module dpd_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/dpd_cmd_enc.sv
module dpd_cmd_enc
    import dpd_pkg::*;
#(
    parameter int              ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  cmd_e              cmd,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);
    localparam int A10 = 10;

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        unique case (cmd)
            CMD_PALL: begin
                ras_n     = 1'b0;
                we_n      = 1'b0;
                addr[A10] = 1'b1;
            end
            CMD_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = MODE_WORD;
            end
            CMD_DPD: begin
                we_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dpd_seq.sv
module dpd_seq
    import dpd_pkg::*;
#(
    parameter int              NBANK     = 4,
    parameter int              ADDR_W    = 13,
    parameter int              TRP_CYC   = 2,
    parameter int              TRC_CYC   = 7,
    parameter int              TMRD_CYC  = 2,
    parameter int              STAB_CYC  = 20000,
    parameter logic [ADDR_W-1:0] MODE_WORD = 13'h0033
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              wake_req,
    input  logic [NBANK-1:0]  bank_open,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              busy
);
    localparam int M1    = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
    localparam int M2    = (M1 > TMRD_CYC) ? M1 : TMRD_CYC;
    localparam int MAXW  = (M2 > STAB_CYC) ? M2 : STAB_CYC;
    localparam int CW    = $clog2(MAXW + 1);
    localparam logic [CW-1:0] LD_TRP  = CW'(TRP_CYC - 1);
    localparam logic [CW-1:0] LD_TRC  = CW'(TRC_CYC - 1);
    localparam logic [CW-1:0] LD_TMRD = CW'(TMRD_CYC - 1);
    localparam logic [CW-1:0] LD_STAB = CW'(STAB_CYC - 1);

    typedef struct packed {
        state_e st;
        logic   second_ref;
        logic   wake_pend;
    } seq_t;

    seq_t          s_d, s_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    cmd_e          cmd;
    logic          any_open;

    assign any_open = |bank_open;

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (s_q.st)
            ST_RDY: begin
                s_d.wake_pend = 1'b0;
                if (sleep_req) s_d.st = any_open ? ST_PRE : ST_ENTER;
            end
            ST_PRE: begin
                s_d.st   = ST_PRE_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_TRP;
            end
            ST_PRE_WAIT: if (tmr_zero) s_d.st = ST_ENTER;
            ST_ENTER:    s_d.st = ST_SLEEP;
            ST_SLEEP: begin
                if (wake_req || s_q.wake_pend) begin
                    s_d.st        = ST_STAB;
                    s_d.wake_pend = 1'b0;
                    tmr_load      = 1'b1;
                    tmr_val       = LD_STAB;
                end
            end
            ST_STAB: if (tmr_zero) s_d.st = ST_PALL;
            ST_PALL: begin
                s_d.st   = ST_PALL_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_TRP;
            end
            ST_PALL_WAIT: begin
                if (tmr_zero) begin
                    s_d.st         = ST_REF;
                    s_d.second_ref = 1'b0;
                end
            end
            ST_REF: begin
                s_d.st   = ST_REF_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_TRC;
            end
            ST_REF_WAIT: begin
                if (tmr_zero) begin
                    if (s_q.second_ref) begin
                        s_d.st = ST_MRS;
                    end else begin
                        s_d.st         = ST_REF;
                        s_d.second_ref = 1'b1;
                    end
                end
            end
            ST_MRS: begin
                s_d.st   = ST_MRS_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_TMRD;
            end
            ST_MRS_WAIT: if (tmr_zero) s_d.st = ST_RDY;
            default: s_d.st = ST_RDY;
        endcase
        // held wake: captured during the entry states
        if ((s_q.st == ST_PRE || s_q.st == ST_PRE_WAIT || s_q.st == ST_ENTER) && wake_req)
            s_d.wake_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_RDY, second_ref: 1'b0, wake_pend: 1'b0};
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (s_q.st)
            ST_PRE, ST_PALL: cmd = CMD_PALL;
            ST_ENTER:        cmd = CMD_DPD;
            ST_REF:          cmd = CMD_REF;
            ST_MRS:          cmd = CMD_MRS;
            default:         cmd = CMD_NOP;
        endcase
    end

    assign cke   = !(s_q.st == ST_ENTER || s_q.st == ST_SLEEP);
    assign ready = (s_q.st == ST_RDY);
    assign busy  = !ready;

    dpd_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dpd_cmd_enc #(.ADDR_W(ADDR_W), .MODE_WORD(MODE_WORD)) u_enc (
        .cmd   (cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr)
    );
endmodule

// File: rtl/dpd_seq_chk.sv
module dpd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ready,
    input logic busy
);
    // R2
    entry_after_cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !cs_n && ras_n && cas_n && !we_n) |-> $past(cke));

    // R4
    asleep_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !$past(cke)) |-> (!cs_n && ras_n && cas_n && we_n));

    // R8
    busy_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !ready);

    // R5
    exit_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !ready);

    // R6
    ready_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cke);
endmodule

bind dpd_seq dpd_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ready (ready),
    .busy  (busy)
);

// File: tb/dpd_seq_bench.sv
module dpd_seq_bench;
    localparam int AW    = 13;
    localparam int NB    = 4;
    localparam int TRP   = 3;
    localparam int TRC   = 4;
    localparam int TMRD  = 2;
    localparam int STAB  = 6;
    localparam logic [AW-1:0] MODE = 13'h0A27;
    localparam int VW    = 1 + 4 + AW + 2;

    localparam logic [3:0] P_NOP  = 4'b0111;
    localparam logic [3:0] P_PALL = 4'b0010;
    localparam logic [3:0] P_REF  = 4'b0001;
    localparam logic [3:0] P_MRS  = 4'b0000;
    localparam logic [3:0] P_DPD  = 4'b0110;
    localparam logic [AW-1:0] A_PALL = 13'h0400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, wake_req = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic cke, cs_n, ras_n, cas_n, we_n, ready, busy;
    logic [AW-1:0] addr;

    always #2 clk = ~clk;

    dpd_seq #(.NBANK(NB), .ADDR_W(AW), .TRP_CYC(TRP), .TRC_CYC(TRC),
              .TMRD_CYC(TMRD), .STAB_CYC(STAB), .MODE_WORD(MODE)) u_dpd_seq (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .bank_open(bank_open), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ready(ready), .busy(busy));

    int total = 0, bad = 0;
    logic [VW-1:0] exp_q[$];
    int            kind_q[$];
    string         tag_q[$];
    bit            m_asleep = 0;
    bit            m_pend = 0;
    bit            finished = 0;

    function automatic logic [VW-1:0] mk(logic k, logic [3:0] p, logic [AW-1:0] a, logic r);
        return {k, p, a, r, ~r};
    endfunction

    task automatic push(logic k, logic [3:0] p, logic [AW-1:0] a, logic r, int kind, string tag);
        exp_q.push_back(mk(k, p, a, r));
        kind_q.push_back(kind);
        tag_q.push_back(tag);
    endtask

    task automatic push_entry(bit banks);
        if (banks) begin
            push(1, P_PALL, A_PALL, 0, 1, "R3");
            for (int i = 0; i < TRP; i++) push(1, P_NOP, '0, 0, 1, "R3");
        end
        push(0, P_DPD, '0, 0, 1, "R2");
        m_asleep = 1;
    endtask

    task automatic push_wake();
        for (int i = 0; i < STAB; i++) push(1, P_NOP, '0, 0, 3, "R5");
        push(1, P_PALL, A_PALL, 0, 3, "R6");
        for (int i = 0; i < TRP; i++) push(1, P_NOP, '0, 0, 3, "R6");
        for (int r = 0; r < 2; r++) begin
            push(1, P_REF, '0, 0, 3, "R6");
            for (int i = 0; i < TRC; i++) push(1, P_NOP, '0, 0, 3, "R6");
        end
        push(1, P_MRS, MODE, 0, 3, "R6");
        for (int i = 0; i < TMRD; i++) push(1, P_NOP, '0, 0, 3, "R8");
        m_asleep = 0;
        m_pend = 0;
    endtask

    // one cycle: compare outputs at the falling edge, then drive inputs for the next rising edge
    task automatic cyc(logic s, logic w, logic [NB-1:0] b);
        logic [VW-1:0] e, act;
        int kind;
        string tag;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            kind = kind_q.pop_front();
            tag = tag_q.pop_front();
        end else if (m_asleep) begin
            e = mk(0, P_NOP, '0, 0); kind = 2; tag = "R4";
        end else begin
            e = mk(1, P_NOP, '0, 1); kind = 0; tag = "R9";
        end
        act = {cke, cs_n, ras_n, cas_n, we_n, addr, ready, busy};
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, e);
        end
        sleep_req = s;
        wake_req  = w;
        bank_open = b;
        if (kind == 0 && s) push_entry(|b);
        else if (kind == 1 && w) m_pend = 1;       // R7 held wake
        else if (kind == 2 && (w || m_pend)) push_wake();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        total++;
        if (!(cke && ready && !busy && !cs_n && ras_n && cas_n && we_n && addr == '0)) begin
            bad++;
            $display("FAIL R1 actual=%b%b%b expected=110", cke, ready, busy);
        end
        idle(2);
        // R9 wake while ready ignored
        cyc(0, 1, '0); cyc(0, 1, 4'b1111); idle(2);
        // R2 entry with all banks closed, R4 sleep requests ignored while down
        cyc(1, 0, '0); idle(3); cyc(1, 0, 4'b0011); cyc(1, 0, '0); idle(2);
        // R5 and R6 exit, R8 busy until ready; sleep during re-init ignored
        cyc(0, 1, '0); idle(4); cyc(1, 0, '0); idle(30);
        // R3 bank open precharge, R7 wake during precharge wait
        cyc(1, 0, 4'b0100); idle(1); cyc(0, 1, '0); idle(40);
        // R7 wake on the same cycle as sleep is ignored (ready), later wake on ENTER cycle
        cyc(1, 1, '0); cyc(0, 1, '0); idle(40);
        // R3 wake in precharge cycle itself
        cyc(1, 0, 4'b1000); cyc(0, 1, '0); idle(40);
        // R4 long sleep, then wake
        cyc(1, 0, 4'b0001); idle(12); cyc(0, 1, '0); idle(40);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule